// File: doc/BRIEF.md
# Display Panel Power and Initialisation Sequencer

This block brings a serially commanded LCD panel controller up and takes it down again. On a bring-up request it switches the panel supplies on with the panel held in reset. It releases reset and waits for the controller to settle. It then streams a fixed set of command packets: software reset, sleep exit, two banks of extended configuration, closing of the extended set, and display-on. On a shut-down request it sends display-off and sleep entry, then asserts reset and finally removes the supplies.

Packets leave through a byte stream with valid/ready flow control. The first byte of each packet (the opcode) is marked, and so is its final byte. All waits are whole milliseconds, timed by a prescaler derived from the clock frequency parameter. The whole programme sits in a small computed ROM whose entries are tagged as opcode, parameter, delay, pin update or end. The porch bytes are derived from the vertical timing parameters of the attached mode.

Top module: `panel_seq`

## Requirements
- R1: After reset, `panel_pwr_en` is 0, `panel_rst_n` is 0, `busy` is 0 and `tx_valid` is 0.
- R2: Bring-up sets `panel_pwr_en` while `panel_rst_n` is still 0. Reset is released 20 ms later. The first command byte is accepted 150 ms after the release.
- R3: A wait of N ms spans between N*T and N*T+3 clock cycles, where T = CLK_HZ/1000. The span is measured from the pin change or final-byte acceptance that precedes the wait to the pin change or byte acceptance that follows it.
- R4: The first two packets are 0x01,0x00 (software reset), followed by a 5 ms wait, and 0x11,0x00 (sleep exit), followed by a wait of 120+EXTRA_MS ms.
- R5: Each bank-select packet is 0xFF,0x77,0x01,0x00,0x00,SEL.
  - SEL=0x10 precedes the line, porch and inversion writes.
  - SEL=0x11 precedes the voltage writes.
  - SEL=0x00 closes the extended set before display-on.
- R6: The configuration packets are fixed as follows.
  - Line setting: 0xC0,0xE9,0x03.
  - Porch: 0xC1, VTOTAL-VSYNC_END, VSYNC_START-VDISPLAY. With the defaults these are 4 and 18.
  - Inversion: 0xC2,0x37,0x06.
  - Voltage: 0xB0,0x45 and then 0xB1,0x13.
- R7: Bring-up ends with 0x29,0x00. Shut-down sends 0x28,0x00 and then 0x10,0x00 and no other bytes.
- R8: Shut-down proceeds in this order:
  - accept the final sleep-entry byte;
  - wait 120+EXTRA_MS ms and drive `panel_rst_n` to 0;
  - wait the same time again and drive `panel_pwr_en` to 0.
- R9: `tx_first` is 1 exactly on each packet's opcode byte. `tx_last` is 1 exactly on each packet's final byte.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values into the next cycle.
- R11: `busy` is 1 from the cycle after an accepted start until the sequence ends. Start requests arriving while busy are dropped and leave no pending run. Bring-up has priority when both starts arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| up_start | input | 1 | Request bring-up (power, reset release, init, display-on) |
| down_start | input | 1 | Request shut-down (display-off, sleep, reset, power-off) |
| busy | output | 1 | A sequence is running |
| panel_pwr_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| tx_data | output | 8 | Command stream byte |
| tx_valid | output | 1 | Byte on tx_data is offered |
| tx_ready | input | 1 | Sink accepts the offered byte |
| tx_first | output | 1 | Offered byte is a packet opcode |
| tx_last | output | 1 | Offered byte ends its packet |

## Verification
The bench runs full bring-up and shut-down cycles twice: once with the sink always ready and once with a periodic stall. It compares every accepted byte and its framing flags with a list assembled from the requirements. It also measures each wait against its millisecond budget.

Several errors are targeted directly:
- An off-by-one in the prescaler would push the 20, 150, 5 and 200 ms gaps outside their window.
- A design that advanced its pointer during a stall would drop or repeat bytes.
- A wrong bank selector, or a porch byte computed with swapped terms, would show as a byte mismatch at a fixed position.
- A start pulse that was latched while busy instead of dropped would launch an unwanted shut-down after bring-up, with a 0x28 appearing in the stream.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int ADDR_W    = 6;
    localparam int VAL_W     = 16;
    localparam int UP_BASE   = 0;
    localparam int DOWN_BASE = 44;

    // Entry tags: opcode byte, parameter byte, millisecond wait,
    // pin update (bit0 supply enable, bit1 reset release), end marker.
    typedef enum logic [2:0] {
        K_OPC = 3'd0,
        K_PRM = 3'd1,
        K_DLY = 3'd2,
        K_PIN = 3'd3,
        K_END = 3'd4
    } kind_t;

    typedef struct packed {
        kind_t            kind;
        logic [VAL_W-1:0] val;
    } entry_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_WAIT = 2'd2
    } state_t;

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
    import panel_seq_pkg::*;
#(
    parameter int EXTRA_MS    = 80,
    parameter int VDISPLAY    = 854,
    parameter int VSYNC_START = 872,
    parameter int VSYNC_END   = 880,
    parameter int VTOTAL      = 884
) (
    input  logic [ADDR_W-1:0] addr_cur,
    input  logic [ADDR_W-1:0] addr_nxt,
    output entry_t            ent_cur,
    output kind_t             kind_nxt
);

    localparam int SLEEP_MS = 120 + EXTRA_MS;
    localparam int BACK_P   = VTOTAL - VSYNC_END;
    localparam int FRONT_P  = VSYNC_START - VDISPLAY;

    function automatic entry_t mk(kind_t k, int v);
        entry_t e;
        e.kind = k;
        e.val  = VAL_W'(v);
        return e;
    endfunction

    // Six-byte extended-set unlock; offset o within packet, selector s.
    function automatic entry_t bank(int o, int s);
        case (o)
            0:       return mk(K_OPC, 'hFF);
            1:       return mk(K_PRM, 'h77);
            2:       return mk(K_PRM, 'h01);
            5:       return mk(K_PRM, s);
            default: return mk(K_PRM, 'h00);
        endcase
    endfunction

    function automatic entry_t lookup(int a);
        if (a >= 10 && a <= 15) return bank(a - 10, 'h10);
        if (a >= 25 && a <= 30) return bank(a - 25, 'h11);
        if (a >= 35 && a <= 40) return bank(a - 35, 'h00);
        case (a)
            0:  return mk(K_PIN, 1);          // supply on, reset held
            1:  return mk(K_DLY, 20);
            2:  return mk(K_PIN, 3);          // reset released
            3:  return mk(K_DLY, 150);
            4:  return mk(K_OPC, 'h01);
            5:  return mk(K_PRM, 'h00);
            6:  return mk(K_DLY, 5);
            7:  return mk(K_OPC, 'h11);
            8:  return mk(K_PRM, 'h00);
            9:  return mk(K_DLY, SLEEP_MS);
            16: return mk(K_OPC, 'hC0);
            17: return mk(K_PRM, 'hE9);
            18: return mk(K_PRM, 'h03);
            19: return mk(K_OPC, 'hC1);
            20: return mk(K_PRM, BACK_P);
            21: return mk(K_PRM, FRONT_P);
            22: return mk(K_OPC, 'hC2);
            23: return mk(K_PRM, 'h37);
            24: return mk(K_PRM, 'h06);
            31: return mk(K_OPC, 'hB0);
            32: return mk(K_PRM, 'h45);
            33: return mk(K_OPC, 'hB1);
            34: return mk(K_PRM, 'h13);
            41: return mk(K_OPC, 'h29);
            42: return mk(K_PRM, 'h00);
            44: return mk(K_OPC, 'h28);
            45: return mk(K_PRM, 'h00);
            46: return mk(K_OPC, 'h10);
            47: return mk(K_PRM, 'h00);
            48: return mk(K_DLY, SLEEP_MS);
            49: return mk(K_PIN, 1);          // reset asserted, supply on
            50: return mk(K_DLY, SLEEP_MS);
            51: return mk(K_PIN, 0);          // supply off
            default: return mk(K_END, 0);
        endcase
    endfunction

    entry_t nxt_e;

    always_comb begin
        ent_cur  = lookup(int'(addr_cur));
        nxt_e    = lookup(int'(addr_nxt));
        kind_nxt = nxt_e.kind;
    end

endmodule

// File: rtl/panel_seq_mstimer.sv
module panel_seq_mstimer
    import panel_seq_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] count,
    output logic             done
);

    localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);

    logic [PW-1:0]    pre_d, pre_q;
    logic [VAL_W-1:0] ms_d, ms_q;

    always_comb begin
        pre_d = pre_q;
        ms_d  = ms_q;
        if (load) begin
            pre_d = '0;
            ms_d  = count;
        end else if (ms_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_d = '0;
                ms_d  = ms_q - 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else begin
            pre_q <= pre_d;
            ms_q  <= ms_d;
        end
    end

    assign done = (ms_q == '0);

endmodule

// File: rtl/panel_seq.sv
module panel_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int EXTRA_MS    = 80,
    parameter int VDISPLAY    = 854,
    parameter int VSYNC_START = 872,
    parameter int VSYNC_END   = 880,
    parameter int VTOTAL      = 884
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_start,
    input  logic       down_start,
    output logic       busy,
    output logic       panel_pwr_en,
    output logic       panel_rst_n,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       tx_first,
    output logic       tx_last
);

    localparam int TICKS_PER_MS = CLK_HZ / 1000;

    typedef struct packed {
        state_t            st;
        logic [ADDR_W-1:0] ptr;
        logic              pwr;
        logic              prst_n;
    } regs_t;

    regs_t  r_d, r_q;
    entry_t ent;
    kind_t  kind_nxt;
    logic   tmr_load, tmr_done, is_byte;

    panel_seq_rom #(
        .EXTRA_MS   (EXTRA_MS),
        .VDISPLAY   (VDISPLAY),
        .VSYNC_START(VSYNC_START),
        .VSYNC_END  (VSYNC_END),
        .VTOTAL     (VTOTAL)
    ) u_rom (
        .addr_cur(r_q.ptr),
        .addr_nxt(r_q.ptr + 1'b1),
        .ent_cur (ent),
        .kind_nxt(kind_nxt)
    );

    panel_seq_mstimer #(
        .TICKS_PER_MS(TICKS_PER_MS)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .count(ent.val),
        .done (tmr_done)
    );

    assign is_byte = (r_q.st == S_RUN) && (ent.kind == K_OPC || ent.kind == K_PRM);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (up_start) begin
                    r_d.st  = S_RUN;
                    r_d.ptr = ADDR_W'(UP_BASE);
                end else if (down_start) begin
                    r_d.st  = S_RUN;
                    r_d.ptr = ADDR_W'(DOWN_BASE);
                end
            end
            S_RUN: begin
                case (ent.kind)
                    K_OPC, K_PRM: begin
                        if (tx_ready) r_d.ptr = r_q.ptr + 1'b1;
                    end
                    K_DLY: begin
                        tmr_load = 1'b1;
                        r_d.ptr  = r_q.ptr + 1'b1;
                        r_d.st   = S_WAIT;
                    end
                    K_PIN: begin
                        r_d.pwr    = ent.val[0];
                        r_d.prst_n = ent.val[1];
                        r_d.ptr    = r_q.ptr + 1'b1;
                    end
                    default: r_d.st = S_IDLE;
                endcase
            end
            S_WAIT: begin
                if (tmr_done) r_d.st = S_RUN;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= S_IDLE;
            r_q.ptr    <= '0;
            r_q.pwr    <= 1'b0;
            r_q.prst_n <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != S_IDLE);
    assign panel_pwr_en = r_q.pwr;
    assign panel_rst_n  = r_q.prst_n;
    assign tx_valid     = is_byte;
    assign tx_data      = ent.val[7:0];
    assign tx_first     = is_byte && (ent.kind == K_OPC);
    assign tx_last      = is_byte && (kind_nxt != K_PRM);

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       up_start,
    input logic       down_start,
    input logic       busy,
    input logic       panel_pwr_en,
    input logic       panel_rst_n,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_first,
    input logic       tx_last
);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                     && $stable(tx_first) && $stable(tx_last)));

    // R2
    rst_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_rst_n) |-> panel_pwr_en);

    // R8
    pwr_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_en) |-> !panel_rst_n);

    // R11
    bytes_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R11
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !up_start && !down_start) |=> !busy);

    // R9
    first_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_first || tx_last) |-> tx_valid);

endmodule

bind panel_seq panel_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_start    (up_start),
    .down_start  (down_start),
    .busy        (busy),
    .panel_pwr_en(panel_pwr_en),
    .panel_rst_n (panel_rst_n),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_first    (tx_first),
    .tx_last     (tx_last)
);

// File: tb/panel_seq_bench.sv
module panel_seq_bench;

    localparam int CLK_HZ = 4000;
    localparam int T      = CLK_HZ / 1000;
    localparam int EXTRA  = 80;
    localparam int SLP    = 120 + EXTRA;
    localparam int VDISP  = 854, VSS = 872, VSE = 880, VTOT = 884;

    logic clk = 1'b0, rst_n = 1'b0, up_start = 1'b0, down_start = 1'b0;
    logic tx_ready = 1'b1;
    logic busy, panel_pwr_en, panel_rst_n, tx_valid, tx_first, tx_last;
    logic [7:0] tx_data;

    always #10 clk = ~clk;

    panel_seq #(
        .CLK_HZ(CLK_HZ), .EXTRA_MS(EXTRA), .VDISPLAY(VDISP),
        .VSYNC_START(VSS), .VSYNC_END(VSE), .VTOTAL(VTOT)
    ) u_panel_seq (
        .clk(clk), .rst_n(rst_n), .up_start(up_start), .down_start(down_start),
        .busy(busy), .panel_pwr_en(panel_pwr_en), .panel_rst_n(panel_rst_n),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_first(tx_first), .tx_last(tx_last)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit stall_mode = 1'b0;

    logic [7:0] exp_b [64];
    bit         exp_f [64], exp_l [64];
    int         nexp;
    logic [7:0] got_b [128];
    bit         got_f [128], got_l [128];
    int         got_t [128];
    int         ngot = 0;
    int t_pwr_rise = 0, t_rst_rise = 0, t_rst_fall = 0, t_pwr_fall = 0;
    int stall_seen = 0, stall_bad = 0, rst_at_pwr = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_gap(string req, int gap, int ms);
        chk(gap >= ms * T && gap <= ms * T + 3, req, gap, ms * T);
    endtask

    task automatic add(int b, bit f, bit l);
        exp_b[nexp] = 8'(b); exp_f[nexp] = f; exp_l[nexp] = l; nexp++;
    endtask

    task automatic pk2(int a, int b);
        add(a, 1, 0); add(b, 0, 1);
    endtask

    task automatic pk3(int a, int b, int c);
        add(a, 1, 0); add(b, 0, 0); add(c, 0, 1);
    endtask

    task automatic bank_sel(int s);
        add('hFF, 1, 0); add('h77, 0, 0); add('h01, 0, 0);
        add(0, 0, 0); add(0, 0, 0); add(s, 0, 1);
    endtask

    task automatic build_up();
        nexp = 0;
        pk2('h01, 0);                          // R4
        pk2('h11, 0);                          // R4
        bank_sel('h10);                        // R5
        pk3('hC0, 'hE9, 'h03);                 // R6
        pk3('hC1, VTOT - VSE, VSS - VDISP);    // R6
        pk3('hC2, 'h37, 'h06);                 // R6
        bank_sel('h11);                        // R5
        pk2('hB0, 'h45);                       // R6
        pk2('hB1, 'h13);                       // R6
        bank_sel('h00);                        // R5
        pk2('h29, 0);                          // R7
    endtask

    task automatic build_down();
        nexp = 0;
        pk2('h28, 0);                          // R7
        pk2('h10, 0);                          // R7
    endtask

    task automatic cmp_stream(string req);
        chk(ngot == nexp, {req, " byte count"}, ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++) begin
            chk(got_b[i] == exp_b[i], {req, " byte"}, int'(got_b[i]), int'(exp_b[i]));
            chk(got_f[i] == exp_f[i], "R9 first flag", int'(got_f[i]), int'(exp_f[i]));
            chk(got_l[i] == exp_l[i], "R9 last flag", int'(got_l[i]), int'(exp_l[i]));
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk(1'b0, "R11 sequence hung", n, 20000);
    endtask

    task automatic start_seq(bit up, int stray_at);
        ngot = 0;
        @(negedge clk);
        if (up) up_start = 1'b1; else down_start = 1'b1;
        @(negedge clk);
        up_start = 1'b0; down_start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        repeat (stray_at) @(negedge clk);
        if (up) down_start = 1'b1; else up_start = 1'b1;   // R11 dropped request
        @(negedge clk);
        up_start = 1'b0; down_start = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R11 no pending run", int'(busy), 0);
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(negedge clk);
        tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    end

    // Monitor: sampled at negedge; an offered byte with ready is taken at edge cyc+1.
    initial begin
        logic pv, pr, pp, prs, pf, pl;
        logic [7:0] pd;
        pv = 0; pr = 0; pp = 0; prs = 0; pd = 0; pf = 0; pl = 0;
        forever begin
            @(negedge clk);
            #1;
            if (pv && !pr) begin
                stall_seen++;
                if (!tx_valid || tx_data != pd || tx_first != pf || tx_last != pl)
                    stall_bad++;
            end
            if (panel_pwr_en && !pp) begin t_pwr_rise = cyc; if (panel_rst_n) rst_at_pwr++; end
            if (!panel_pwr_en && pp) t_pwr_fall = cyc;
            if (panel_rst_n && !prs) t_rst_rise = cyc;
            if (!panel_rst_n && prs) t_rst_fall = cyc;
            if (tx_valid && tx_ready && ngot < 128) begin
                got_b[ngot] = tx_data; got_f[ngot] = tx_first;
                got_l[ngot] = tx_last; got_t[ngot] = cyc + 1;
                ngot++;
            end
            pv = tx_valid; pr = tx_ready; pd = tx_data; pf = tx_first; pl = tx_last;
            pp = panel_pwr_en; prs = panel_rst_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1
        chk(panel_pwr_en == 0, "R1 supply off", int'(panel_pwr_en), 0);
        chk(panel_rst_n == 0, "R1 reset low", int'(panel_rst_n), 0);
        chk(busy == 0, "R1 idle", int'(busy), 0);
        chk(tx_valid == 0, "R1 no byte", int'(tx_valid), 0);

        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);
            build_up();
            start_seq(1'b1, 40);
            cmp_stream("R5 R6 up stream");
            chk(rst_at_pwr == 0, "R2 reset held at power on", rst_at_pwr, 0);
            chk(panel_pwr_en && panel_rst_n, "R2 powered and released",
                int'({panel_pwr_en, panel_rst_n}), 3);
            if (!stall_mode && ngot >= 5) begin
                chk_gap("R2 R3 power to release", t_rst_rise - t_pwr_rise, 20);
                chk_gap("R2 R3 release to first cmd", got_t[0] - t_rst_rise, 150);
                chk_gap("R4 soft reset wait", got_t[2] - got_t[1], 5);
                chk_gap("R4 sleep exit wait", got_t[4] - got_t[3], SLP);
            end
            build_down();
            start_seq(1'b0, 40);
            cmp_stream("R7 down stream");
            chk(!panel_pwr_en && !panel_rst_n, "R8 off and in reset",
                int'({panel_pwr_en, panel_rst_n}), 0);
            if (!stall_mode && ngot >= 4) begin
                chk_gap("R8 sleep entry to reset", t_rst_fall - got_t[3], SLP);
                chk_gap("R8 reset to power off", t_pwr_fall - t_rst_fall, SLP);
            end
        end
        // R10
        chk(stall_seen > 0, "R10 stalls exercised", stall_seen, 1);
        chk(stall_bad == 0, "R10 output held in stall", stall_bad, 0);

        // R11 both starts together: bring-up wins
        build_up();
        ngot = 0;
        @(negedge clk);
        up_start = 1'b1; down_start = 1'b1;
        @(negedge clk);
        up_start = 1'b0; down_start = 1'b0;
        wait_idle();
        chk(ngot > 0 && got_b[0] == 8'h01, "R11 bring-up priority",
            ngot > 0 ? int'(got_b[0]) : -1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule